// File: doc/BRIEF.md
# Serial Table-Access Command Engine

This block is the target-side engine that serves a two-wire programming link after program mode has been entered. A host toggles a serial clock and presents data on a serial data line. Every transaction is a frame of 20 serial clocks: a 4-bit command and then a 16-bit operand. The engine decodes the command and uses a 22-bit table pointer to read bytes from an internal byte memory, to stage bytes in a write buffer, or to program the buffer into memory.

For reads, the engine takes control of the data line during the second half of the operand and returns a byte. A reduced loader stands in for core-instruction execution and only sets the three pointer bytes. Flash programming time is modelled as a busy interval of a fixed number of system clocks. During that interval the block copies the buffer into memory one byte per clock and ignores the serial link.

The serial clock and data are synchronous inputs sampled by the system clock. A serial clock edge is seen one system clock after the level changes, so each serial clock level must be held for at least two system clocks.

Top module: `serial_table_engine`

## Requirements
- R1: A frame is 20 falling edges of `serClk`. The first 4 bits are the command and the next 16 bits are the operand, each least significant bit first, and a bit is taken at the falling edge. In the command codes below, the leftmost digit is command bit 3.
- R2: Command 0000 is the pointer loader, applied at the end of the frame. Operand bits [9:8] select the target: 01 sets pointer bits [7:0] from operand [7:0], 10 sets bits [15:8] from operand [7:0], and 11 sets bits [21:16] from operand [5:0]. The value 00 leaves the pointer unchanged.
- R3: The read commands return the memory byte addressed by the pointer and update the pointer as follows. 1000 leaves it unchanged. 1001 adds 1 after the read. 1010 subtracts 1 after the read. 1011 adds 1 before the read and reads the new address.
- R4: A returned byte is driven least significant bit first. Bit 0 is valid after the 12th falling edge, and each later bit follows the next falling edge. `serDataOe` is high from the 12th falling edge, stays high to the end of the frame, and drops at the first rising edge of the next frame. While `serDataOe` is low, `serDataOut` is 0.
- R5: Command 0010 drives out the byte held from the last read. It does not access memory and does not change the pointer.
- R6: Addresses at or above `MEM_BYTES` read as 0, and programming them has no effect. The pointer wraps modulo 2^22, so a pre-increment from 3FFFFFh reads address 0.
- R7: Commands 1100 and 1101 store operand [7:0] in buffer entry {ptr[5:1],0} and operand [15:8] in entry {ptr[5:1],1}. Command 1101 then adds 2 to the pointer; 1100 leaves it unchanged.
- R8: Commands 1110 and 1111 store a word into the buffer as in R7 and then program all 64 buffer bytes into the 64-byte-aligned block that contains the pointer, taking the pointer value before any step. Command 1110 then adds 2 to the pointer. The buffer keeps its contents after programming.
- R9: After a programming command, `busy` rises one system clock after the 20th falling edge and stays high for exactly `PROG_CYCLES` system clocks. Serial clock edges seen while `busy` is high are ignored.
- R10: After reset the pointer is 0, every buffer byte is FFh, memory byte i holds i XOR `MEM_SEED`, and `serDataOe`, `serDataOut` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock from the host, sampled by `clk` |
| serDataIn | input | 1 | Serial data from the host |
| serDataOut | output | 1 | Serial data returned to the host |
| serDataOe | output | 1 | High while the engine drives the data line |
| busy | output | 1 | Programming interval in progress |

## Verification
A serial falling edge is detected at the first system clock edge after `serClk` goes low, and every pointer, buffer or output register updates at that same edge. A returned bit is therefore stable one system clock after the falling edge. The bench holds each serial level for two system clocks and samples at the following falling system clock edge, which places every sample well after its update. `busy` is high during the system clock after the final falling edge of a programming frame, so the bench counts that cycle and then counts falling clock edges until `busy` drops, expecting `PROG_CYCLES` in total. Pointer steps are observed through a plain read issued right after each command.

// File: rtl/ste_pkg.sv
package ste_pkg;

  typedef enum logic [1:0] {
    STEP_NONE,
    STEP_INC1,
    STEP_DEC1,
    STEP_INC2
  } ptrStepE;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic    doRead;
    logic    preInc;
    ptrStepE step;
    logic    coreLoad;
    logic    bufWrite;
    logic    progCapture;
    logic    driveOn;
    logic    driveOff;
    logic    shiftOut;
    logic    progWrite;
  } strobeT;

  localparam logic [3:0] CMD_CORE     = 4'b0000;
  localparam logic [3:0] CMD_LATCH    = 4'b0010;
  localparam logic [3:0] CMD_WR       = 4'b1100;
  localparam logic [3:0] CMD_WR_INC   = 4'b1101;
  localparam logic [3:0] CMD_PROG_INC = 4'b1110;
  localparam logic [3:0] CMD_PROG     = 4'b1111;

  localparam logic [1:0] SEL_LOW   = 2'b01;
  localparam logic [1:0] SEL_HIGH  = 2'b10;
  localparam logic [1:0] SEL_UPPER = 2'b11;

endpackage

// File: rtl/ste_ctrl.sv
module ste_ctrl
  import ste_pkg::*;
#(
  parameter int BUF_BYTES   = 64,
  parameter int PROG_CYCLES = 80,
  localparam int BUF_AW     = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serDataIn,
  output strobeT            st,
  output logic [15:0]       operand,
  output logic [BUF_AW-1:0] progIdx,
  output logic              busy
);

  localparam int CMD_BITS   = 4;
  localparam int OP_BITS    = 16;
  localparam int FRAME_BITS = CMD_BITS + OP_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int PCNT_W     = $clog2(PROG_CYCLES + 1);

  localparam logic [CNT_W-1:0] CMD_DONE  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] OUT_FIRST = CNT_W'(CMD_BITS + OP_BITS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
  localparam logic [PCNT_W-1:0] PROG_END = PCNT_W'(PROG_CYCLES - 1);
  localparam logic [PCNT_W-1:0] COPY_END = PCNT_W'(BUF_BYTES);

  logic                clkQ;
  logic                fallEdge;
  logic                riseEdge;
  logic [CNT_W-1:0]    bitCnt;
  logic [CMD_BITS-2:0] cmdLow;
  logic [CMD_BITS-1:0] cmdNow;
  logic [CMD_BITS-1:0] cmdHold;
  logic [OP_BITS-1:0]  opShift;
  logic [PCNT_W-1:0]   progCnt;
  logic                busyQ;
  logic                progStart;
  logic                holdIsOut;

  assign fallEdge  = clkQ && !serClk && !busyQ;
  assign riseEdge  = !clkQ && serClk && !busyQ;
  assign cmdNow    = {serDataIn, cmdLow};
  assign holdIsOut = (cmdHold[3:2] == 2'b10) || (cmdHold == CMD_LATCH);
  assign busy      = busyQ;
  assign progIdx   = progCnt[BUF_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkQ    <= 1'b0;
      bitCnt  <= '0;
      cmdLow  <= '0;
      cmdHold <= '0;
      opShift <= '0;
      progCnt <= '0;
      busyQ   <= 1'b0;
    end else begin
      clkQ <= serClk;
      if (fallEdge) begin
        bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        if (bitCnt < CMD_DONE) cmdLow <= {serDataIn, cmdLow[CMD_BITS-2:1]};
        if (bitCnt == CMD_DONE) cmdHold <= cmdNow;
        if (bitCnt > CMD_DONE) opShift <= {serDataIn, opShift[OP_BITS-1:1]};
      end
      if (progStart) begin
        busyQ   <= 1'b1;
        progCnt <= '0;
      end else if (busyQ) begin
        if (progCnt == PROG_END) busyQ <= 1'b0;
        else progCnt <= progCnt + 1'b1;
      end
    end
  end

  always_comb begin
    st        = '0;
    progStart = 1'b0;
    operand   = {serDataIn, opShift[OP_BITS-1:1]};
    if (fallEdge) begin
      if (bitCnt == CMD_DONE && cmdNow[3:2] == 2'b10) begin
        st.doRead = 1'b1;
        st.preInc = (cmdNow[1:0] == 2'b11);
        case (cmdNow[1:0])
          2'b01:   st.step = STEP_INC1;
          2'b10:   st.step = STEP_DEC1;
          default: st.step = STEP_NONE;
        endcase
      end
      if (bitCnt == OUT_FIRST && holdIsOut) st.driveOn = 1'b1;
      if (bitCnt > OUT_FIRST && bitCnt < LAST_BIT && holdIsOut) st.shiftOut = 1'b1;
      if (bitCnt == LAST_BIT) begin
        case (cmdHold)
          CMD_CORE:   st.coreLoad = 1'b1;
          CMD_WR:     st.bufWrite = 1'b1;
          CMD_WR_INC: begin
            st.bufWrite = 1'b1;
            st.step     = STEP_INC2;
          end
          CMD_PROG_INC: begin
            st.bufWrite    = 1'b1;
            st.progCapture = 1'b1;
            st.step        = STEP_INC2;
            progStart      = 1'b1;
          end
          CMD_PROG: begin
            st.bufWrite    = 1'b1;
            st.progCapture = 1'b1;
            progStart      = 1'b1;
          end
          default: ;
        endcase
      end
    end
    if (riseEdge && bitCnt == '0) st.driveOff = 1'b1;
    st.progWrite = busyQ && (progCnt < COPY_END);
  end

endmodule

// File: rtl/ste_datapath.sv
module ste_datapath
  import ste_pkg::*;
#(
  parameter int PTR_W          = 22,
  parameter int MEM_BYTES      = 256,
  parameter int BUF_BYTES      = 64,
  parameter logic [7:0] MEM_SEED = 8'hA5,
  localparam int BUF_AW        = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            st,
  input  logic [15:0]       operand,
  input  logic [BUF_AW-1:0] progIdx,
  output logic [PTR_W-1:0]  tablePtr,
  output logic              serDataOut,
  output logic              serDataOe
);

  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int BLK_W  = PTR_W - BUF_AW;
  localparam logic [PTR_W-1:0] MEM_LIMIT = PTR_W'(MEM_BYTES);

  logic [7:0]        mem [MEM_BYTES];
  logic [7:0]        wrBuf [BUF_BYTES];
  logic [PTR_W-1:0]  ptrQ;
  logic [PTR_W-1:0]  rdAddr;
  logic [PTR_W-1:0]  nextPtr;
  logic [PTR_W-1:0]  loadPtr;
  logic [PTR_W-1:0]  progAddr;
  logic [BLK_W-1:0]  blockQ;
  logic [7:0]        rdByte;
  logic [7:0]        latchQ;
  logic [7:0]        outSh;
  logic              oeQ;
  logic [BUF_AW-1:0] evenIdx;
  logic [BUF_AW-1:0] oddIdx;

  assign tablePtr   = ptrQ;
  assign serDataOe  = oeQ;
  assign serDataOut = oeQ & outSh[0];
  assign evenIdx    = {ptrQ[BUF_AW-1:1], 1'b0};
  assign oddIdx     = {ptrQ[BUF_AW-1:1], 1'b1};
  assign progAddr   = {blockQ, progIdx};

  always_comb begin
    rdAddr = st.preInc ? ptrQ + PTR_W'(1) : ptrQ;
    rdByte = (rdAddr < MEM_LIMIT) ? mem[rdAddr[MEM_AW-1:0]] : 8'h00;
    case (st.step)
      STEP_INC1: nextPtr = rdAddr + PTR_W'(1);
      STEP_DEC1: nextPtr = rdAddr - PTR_W'(1);
      STEP_INC2: nextPtr = rdAddr + PTR_W'(2);
      default:   nextPtr = rdAddr;
    endcase
    loadPtr = ptrQ;
    case (operand[9:8])
      SEL_LOW:   loadPtr[7:0]        = operand[7:0];
      SEL_HIGH:  loadPtr[15:8]       = operand[7:0];
      SEL_UPPER: loadPtr[PTR_W-1:16] = operand[PTR_W-17:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ   <= '0;
      latchQ <= '0;
      blockQ <= '0;
      outSh  <= '0;
      oeQ    <= 1'b0;
    end else begin
      ptrQ <= st.coreLoad ? loadPtr : nextPtr;
      if (st.doRead) latchQ <= rdByte;
      if (st.progCapture) blockQ <= ptrQ[PTR_W-1:BUF_AW];
      if (st.driveOn) begin
        outSh <= latchQ;
        oeQ   <= 1'b1;
      end else if (st.shiftOut) begin
        outSh <= {1'b0, outSh[7:1]};
      end
      if (st.driveOff) oeQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) wrBuf[i] <= 8'hFF;
    end else if (st.bufWrite) begin
      wrBuf[evenIdx] <= operand[7:0];
      wrBuf[oddIdx]  <= operand[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i) ^ MEM_SEED;
    end else if (st.progWrite && progAddr < MEM_LIMIT) begin
      mem[progAddr[MEM_AW-1:0]] <= wrBuf[progIdx];
    end
  end

endmodule

// File: rtl/serial_table_engine.sv
module serial_table_engine
  import ste_pkg::*;
#(
  parameter int PTR_W            = 22,
  parameter int MEM_BYTES        = 256,
  parameter int BUF_BYTES        = 64,
  parameter int PROG_CYCLES      = 80,
  parameter logic [7:0] MEM_SEED = 8'hA5
) (
  input  logic clk,
  input  logic rstN,
  input  logic serClk,
  input  logic serDataIn,
  output logic serDataOut,
  output logic serDataOe,
  output logic busy
);

  localparam int BUF_AW = $clog2(BUF_BYTES);

  strobeT            st;
  logic [15:0]       operand;
  logic [BUF_AW-1:0] progIdx;
  logic [PTR_W-1:0]  tablePtr;

  ste_ctrl #(
    .BUF_BYTES  (BUF_BYTES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .serClk   (serClk),
    .serDataIn(serDataIn),
    .st       (st),
    .operand  (operand),
    .progIdx  (progIdx),
    .busy     (busy)
  );

  ste_datapath #(
    .PTR_W    (PTR_W),
    .MEM_BYTES(MEM_BYTES),
    .BUF_BYTES(BUF_BYTES),
    .MEM_SEED (MEM_SEED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .operand   (operand),
    .progIdx   (progIdx),
    .tablePtr  (tablePtr),
    .serDataOut(serDataOut),
    .serDataOe (serDataOe)
  );

endmodule

// File: rtl/ste_checker.sv
module ste_checker #(
  parameter int PTR_W       = 22,
  parameter int PROG_CYCLES = 80
) (
  input logic             clk,
  input logic             rstN,
  input logic             serClk,
  input logic             serDataOut,
  input logic             serDataOe,
  input logic             busy,
  input logic [PTR_W-1:0] tablePtr
);

  localparam int LEN_W = $clog2(PROG_CYCLES + 2);

  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !serDataOe |-> !serDataOut);

  p_release_on_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serDataOe) |-> serClk);

  p_no_drive_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !serDataOe);

  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(tablePtr));

  p_busy_length_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == LEN_W'(PROG_CYCLES));

endmodule

bind serial_table_engine ste_checker #(
  .PTR_W      (PTR_W),
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .serClk    (serClk),
  .serDataOut(serDataOut),
  .serDataOe (serDataOe),
  .busy      (busy),
  .tablePtr  (tablePtr)
);

// File: tb/serial_table_engine_test.sv
`timescale 1ns/1ps
module serial_table_engine_test;

  localparam int PTR_W       = 22;
  localparam int MEM_BYTES   = 256;
  localparam int BUF_BYTES   = 64;
  localparam int PROG_CYCLES = 80;
  localparam logic [7:0] SEED = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serDataIn = 1'b0;
  logic serDataOut;
  logic serDataOe;
  logic busy;

  int nRun = 0;
  int nFail = 0;

  logic [7:0]       mdlMem [MEM_BYTES];
  logic [7:0]       mdlBuf [BUF_BYTES];
  logic [PTR_W-1:0] mdlPtr;
  logic [7:0]       rdByte;
  logic             oeSeen;

  serial_table_engine #(
    .PTR_W(PTR_W), .MEM_BYTES(MEM_BYTES), .BUF_BYTES(BUF_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .MEM_SEED(SEED)
  ) uut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serDataIn(serDataIn),
    .serDataOut(serDataOut), .serDataOe(serDataOe), .busy(busy)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRead(input logic [PTR_W-1:0] a);
    return (a < PTR_W'(MEM_BYTES)) ? mdlMem[a[7:0]] : 8'h00;
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk);
    serDataIn = b;
    serClk = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    serClk = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic xfer(input logic [3:0] cmd, input logic [15:0] op);
    logic isOut;
    isOut = (cmd[3:2] == 2'b10) || (cmd == 4'b0010);
    rdByte = '0;
    oeSeen = 1'b1;
    for (int i = 0; i < 4; i++) pulse(cmd[i]);
    for (int i = 0; i < 16; i++) begin
      if (i == 0) begin
        @(negedge clk);
        check(serDataOe == 1'b0, "R4 released after first rise", 32'(serDataOe), 32'h0);
      end
      if (isOut && i >= 8) begin
        @(negedge clk);
        rdByte[i-8] = serDataOut;
        if (!serDataOe) oeSeen = 1'b0;
      end
      pulse((isOut && i >= 8) ? 1'b0 : op[i]);
    end
  endtask

  task automatic setPtr(input logic [PTR_W-1:0] a);
    xfer(4'b0000, {6'b0, 2'b11, 2'b00, a[21:16]});
    xfer(4'b0000, {6'b0, 2'b10, a[15:8]});
    xfer(4'b0000, {6'b0, 2'b01, a[7:0]});
    mdlPtr = a;
  endtask

  task automatic readCmp(input logic [3:0] cmd, input string tag);
    logic [7:0] exp;
    case (cmd[1:0])
      2'b00: exp = mRead(mdlPtr);
      2'b01: begin exp = mRead(mdlPtr); mdlPtr = mdlPtr + 1'b1; end
      2'b10: begin exp = mRead(mdlPtr); mdlPtr = mdlPtr - 1'b1; end
      default: begin mdlPtr = mdlPtr + 1'b1; exp = mRead(mdlPtr); end
    endcase
    xfer(cmd, 16'h0000);
    check(rdByte == exp, tag, 32'(rdByte), 32'(exp));
    check(oeSeen, "R4 drive window", 32'(oeSeen), 32'h1);
  endtask

  task automatic writeCmd(input logic [3:0] cmd, input logic [15:0] op);
    logic [PTR_W-1:0] base;
    logic [PTR_W-1:0] a;
    mdlBuf[{mdlPtr[5:1], 1'b0}] = op[7:0];
    mdlBuf[{mdlPtr[5:1], 1'b1}] = op[15:8];
    if (cmd[1]) begin
      base = {mdlPtr[PTR_W-1:6], 6'b0};
      for (int j = 0; j < BUF_BYTES; j++) begin
        a = base + PTR_W'(j);
        if (a < PTR_W'(MEM_BYTES)) mdlMem[a[7:0]] = mdlBuf[j];
      end
    end
    if (cmd == 4'b1101 || cmd == 4'b1110) mdlPtr = mdlPtr + PTR_W'(2);
    xfer(cmd, op);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #400000;
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    logic [PTR_W-1:0] addrs [6];
    logic [PTR_W-1:0] a;
    logic [7:0] held;
    addrs[0] = 22'h000000; addrs[1] = 22'h000001; addrs[2] = 22'h00007F;
    addrs[3] = 22'h0000FF; addrs[4] = 22'h000100; addrs[5] = 22'h3FFFFF;
    for (int i = 0; i < MEM_BYTES; i++) mdlMem[i] = 8'(i) ^ SEED;
    for (int i = 0; i < BUF_BYTES; i++) mdlBuf[i] = 8'hFF;
    mdlPtr = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(serDataOe == 1'b0, "R10 reset oe", 32'(serDataOe), 32'h0);
    check(serDataOut == 1'b0, "R10 reset data", 32'(serDataOut), 32'h0);
    check(busy == 1'b0, "R10 reset busy", 32'(busy), 32'h0);
    readCmp(4'b1000, "R10 reset pointer and memory");

    // R2: loader with select 00 has no effect
    setPtr(22'h000033);
    xfer(4'b0000, 16'h00FF);
    readCmp(4'b1000, "R2 select 00 ignored");

    // R3/R6: every read mode at boundary addresses, then a plain read observes the pointer
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 6; k++) begin
        setPtr(addrs[k]);
        readCmp(4'b1000 | 4'(m), "R3 R6 read mode byte");
        readCmp(4'b1000, "R3 R6 pointer after step");
      end
    end

    // R5: latch replay leaves pointer alone
    setPtr(22'h000050);
    readCmp(4'b1000, "R5 prime latch");
    held = mRead(22'h000050);
    xfer(4'b0010, 16'h0000);
    check(rdByte == held, "R5 latch replay", 32'(rdByte), 32'(held));
    readCmp(4'b1000, "R5 pointer unchanged");

    // R7/R8/R9: fill block 40h and program with post-increment
    setPtr(22'h000040);
    for (int k = 0; k < 32; k++) begin
      writeCmd((k == 31) ? 4'b1110 : 4'b1101, {8'(k * 7 + 1), 8'(k * 3)});
    end
    n = 1;
    forever begin
      @(negedge clk);
      if (busy) n++;
      else break;
    end
    check(n == PROG_CYCLES, "R9 busy length", 32'(n), 32'(PROG_CYCLES));
    readCmp(4'b1000, "R8 pointer after 1110");
    setPtr(22'h000040);
    for (int k = 0; k < 64; k++) readCmp(4'b1001, "R8 programmed block 40h");

    // R7: 1100 keeps pointer; R8: 1111 keeps pointer, buffer retained
    setPtr(22'h000084);
    writeCmd(4'b1100, 16'hBEEF);
    readCmp(4'b1000, "R7 pointer unchanged by 1100");
    setPtr(22'h000086);
    writeCmd(4'b1111, 16'h1234);
    waitIdle();
    readCmp(4'b1000, "R8 pointer unchanged by 1111");
    setPtr(22'h000080);
    for (int k = 0; k < 64; k++) readCmp(4'b1001, "R8 retained buffer in block 80h");

    // R6: programming an unimplemented block has no effect
    setPtr(22'h000100);
    writeCmd(4'b1111, 16'h5555);
    waitIdle();
    readCmp(4'b1000, "R6 unimplemented after program");

    // R9: serial edges during busy are ignored
    setPtr(22'h0000C4);
    writeCmd(4'b1111, 16'h7788);
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      serDataIn = 1'b1;
      serClk = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      serClk = 1'b0;
      repeat (2) @(posedge clk);
    end
    @(negedge clk);
    check(busy == 1'b1, "R9 still busy after toggles", 32'(busy), 32'h1);
    serDataIn = 1'b0;
    waitIdle();
    readCmp(4'b1001, "R9 frame intact after busy");
    readCmp(4'b1001, "R9 pointer intact after busy");
    a = 22'h0000C0;
    for (int k = 0; k < 4; k++) begin
      setPtr(a + PTR_W'(k));
      readCmp(4'b1000, "R1 R8 block C0h bytes");
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule